// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Transmitter

This block turns a stream of 16-bit stereo sample pairs into the consumer serial digital audio format and puts it on a single line in biphase-mark code. Every sample pair becomes one frame made of two subframes, left then right. Each subframe carries a sync preamble, an auxiliary and extension field that is sent as zeros, the audio word, and four flag bits: validity, user, channel status and parity. The frames are grouped into blocks of 192. The channel-status bit is one bit per frame, indexed by the frame's position in the block.

The block runs on a clock at twice the line cell rate, so each clock cycle produces one half-cell of the line. An upstream sample source pulses the sample strobe once per frame with a left/right pair and one interpolation flag per channel. The newest pair captured before a frame starts is the pair that frame sends. The validity bit marks samples that the error concealer interpolated. The user bit is taken from a serial user-data stream, which is sampled at the start of each subframe. A two-bit clock-accuracy level from the host fills the accuracy field of the channel status. When the output enable is low, the line driver is released, but the internal timing keeps running.

Top module: `bmc_audio_tx`

## Requirements
- R1: A subframe is 32 cells (64 clock cycles). Cells 0 to 3 hold the preamble, cells 4 to 11 carry zeros, cells 12 to 27 carry the audio sample with its LSB first (cell 12 = bit 0), and cells 28, 29, 30 and 31 carry V, U, C and P.
- R2: The preamble occupies 8 half-cells. Referred to a previous line level of 0, the patterns, first half-cell first, are B = 11101000, M = 11100010 and W = 11100100. When the previous level is 1, the pattern is inverted. Right subframes use W and left subframes use M, except as R3 states.
- R3: A block is 192 frames, counted from 0 after reset. The left subframe of frame 0 of every block uses preamble B.
- R4: The V bit (cell 28) equals the interpolation flag that was captured with that channel's sample.
- R5: The U bit (cell 29) equals user_i as sampled in the clock cycle of the subframe's first half-cell.
- R6: The C bit (cell 30) of both subframes of frame f is channel-status bit f. Bit 28 equals acc_i[0], bit 29 equals acc_i[1], and every other bit is 0. acc_i is sampled at the start of each subframe.
- R7: The P bit (cell 31) makes the count of ones in cells 4 to 31 even.
- R8: In cells 4 to 31 the line toggles at every cell boundary and toggles again at mid-cell when the bit is 1. The first half-cell of every preamble differs from the last half-cell before it.
- R9: One cycle after en_i is sampled low, line_oe_o is 0 and line_o is held at 0. The cell and frame timing keeps counting, so the first subframe after en_i returns high is sent in full at its usual place.
- R10: A pulse on smp_vld_i captures smp_l_i, smp_r_i and both interpolation flags. Each frame sends the last pair captured before its left subframe starts. Before the first capture after reset, it sends zero samples with V = 0.
- R11: During reset, line_o and line_oe_o are 0. The first clock edge after reset is released outputs the first half-cell of a B preamble from a previous level of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the line cell rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Output enable; low releases the line driver |
| smp_vld_i | input | 1 | Sample strobe, one cycle per pair |
| smp_l_i | input | 16 | Left audio sample |
| smp_r_i | input | 16 | Right audio sample |
| interp_l_i | input | 1 | Left sample was interpolated |
| interp_r_i | input | 1 | Right sample was interpolated |
| user_i | input | 1 | User-data stream bit |
| acc_i | input | 2 | Clock-accuracy level for the channel status |
| line_o | output | 1 | Biphase-mark coded line |
| line_oe_o | output | 1 | Line driver enable (low = high impedance) |

## Verification
A wrong cell or frame counter shows at the line within one subframe, which is 64 cycles. The preamble shape is wrong, or the B preamble lands on the wrong frame, or the channel-status accuracy bits appear in frames other than 28 and 29. A wrong line level or a wrong preamble reference register breaks a cell-boundary toggle or the preamble polarity in the half-cell where it happens. The bench decodes every half-cell of every subframe over two full blocks, so such an error is seen at once. A bad parity or word-assembly path shows in the decoded bits of the very subframe it builds.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

   // preamble kinds
   typedef enum logic [1:0] {
      PRE_BLK = 2'd0,   // left subframe opening a block
      PRE_LFT = 2'd1,   // other left subframes
      PRE_RGT = 2'd2    // right subframes
   } pre_kind_e;

   localparam int unsigned PRE_HALVES = 8;
   localparam int unsigned PRE_CELLS  = 4;
   localparam int unsigned FLAG_CELLS = 4;

   // preamble shape referred to a previous line level of 0, first half-cell in bit 7
   function automatic logic [7:0] pre_shape(input pre_kind_e kind);
      logic [7:0] s;
      case (kind)
         PRE_BLK: s = 8'b1110_1000;
         PRE_LFT: s = 8'b1110_0010;
         PRE_RGT: s = 8'b1110_0100;
         default: s = 8'b1110_0010;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/bmc_tx_timer.sv
module bmc_tx_timer #(
   parameter int unsigned HALVES       = 64,
   parameter int unsigned BLOCK_FRAMES = 192,
   localparam int unsigned HC_W        = $clog2(HALVES),
   localparam int unsigned FR_W        = $clog2(BLOCK_FRAMES)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [HC_W-1:0] hc_o,
   output logic            right_o,
   output logic [FR_W-1:0] frame_o,
   output logic            sf_start_o,
   output logic            frame_start_o
);

   logic [HC_W-1:0] hc_q;
   logic            right_q;
   logic [FR_W-1:0] frame_q;
   logic            sf_last;
   logic            blk_last;

   assign sf_last  = (hc_q == HC_W'(HALVES - 1));
   assign blk_last = (frame_q == FR_W'(BLOCK_FRAMES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc_q    <= '0;
         right_q <= 1'b0;
         frame_q <= '0;
      end else if (sf_last) begin
         hc_q    <= '0;
         right_q <= ~right_q;
         if (right_q) begin
            frame_q <= blk_last ? '0 : frame_q + 1'b1;
         end
      end else begin
         hc_q <= hc_q + 1'b1;
      end
   end

   assign hc_o          = hc_q;
   assign right_o       = right_q;
   assign frame_o       = frame_q;
   assign sf_start_o    = (hc_q == '0);
   assign frame_start_o = sf_start_o & ~right_q;

endmodule

// File: rtl/bmc_tx_word.sv
module bmc_tx_word #(
   parameter int unsigned SAMPLE_W     = 16,
   parameter int unsigned AUX_W        = 4,
   parameter int unsigned EXT_W        = 4,
   parameter int unsigned BLOCK_FRAMES = 192,
   parameter int unsigned ACC_W        = 2,
   parameter int unsigned ACC_POS      = 28,
   localparam int unsigned FR_W        = $clog2(BLOCK_FRAMES),
   localparam int unsigned DATA_CELLS  = AUX_W + EXT_W + SAMPLE_W + bmc_tx_pkg::FLAG_CELLS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  smp_vld_i,
   input  logic [SAMPLE_W-1:0]   smp_l_i,
   input  logic [SAMPLE_W-1:0]   smp_r_i,
   input  logic                  interp_l_i,
   input  logic                  interp_r_i,
   input  logic                  user_i,
   input  logic [ACC_W-1:0]      acc_i,
   input  logic                  sf_start_i,
   input  logic                  frame_start_i,
   input  logic                  right_i,
   input  logic [FR_W-1:0]       frame_i,
   output logic [DATA_CELLS-1:0] word_o
);

   logic [SAMPLE_W-1:0]   hold_l, hold_r, cur_r;
   logic                  hold_vl, hold_vr, cur_vr;
   logic [SAMPLE_W-1:0]   sel_smp;
   logic                  sel_v;
   logic [ACC_W-1:0]      cs_hit;
   logic                  cs_bit;
   logic [DATA_CELLS-2:0] body;
   logic [DATA_CELLS-1:0] word_q;

   // capture of the newest pair
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_l  <= '0;
         hold_r  <= '0;
         hold_vl <= 1'b0;
         hold_vr <= 1'b0;
      end else if (smp_vld_i) begin
         hold_l  <= smp_l_i;
         hold_r  <= smp_r_i;
         hold_vl <= interp_l_i;
         hold_vr <= interp_r_i;
      end
   end

   // right sample frozen at frame start so it belongs to the same pair as the left one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_r  <= '0;
         cur_vr <= 1'b0;
      end else if (frame_start_i) begin
         cur_r  <= hold_r;
         cur_vr <= hold_vr;
      end
   end

   assign sel_smp = right_i ? cur_r  : hold_l;
   assign sel_v   = right_i ? cur_vr : hold_vl;

   // channel-status accuracy field, one frame position per level bit
   for (genvar gi = 0; gi < ACC_W; gi++) begin : g_acc
      assign cs_hit[gi] = (frame_i == FR_W'(ACC_POS + gi)) & acc_i[gi];
   end
   assign cs_bit = |cs_hit;

   assign body = {cs_bit, user_i, sel_v, sel_smp, {EXT_W{1'b0}}, {AUX_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (sf_start_i) begin
         word_q <= {^body, body};
      end
   end

   assign word_o = word_q;

endmodule

// File: rtl/bmc_tx_line.sv
module bmc_tx_line #(
   parameter int unsigned HALVES       = 64,
   localparam int unsigned HC_W        = $clog2(HALVES),
   localparam int unsigned CELLS       = HALVES / 2,
   localparam int unsigned DATA_CELLS  = CELLS - bmc_tx_pkg::PRE_CELLS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [HC_W-1:0]          hc_i,
   input  bmc_tx_pkg::pre_kind_e    pre_i,
   input  logic [DATA_CELLS-1:0]    word_i,
   output logic                     lvl_o
);

   logic             lvl_q, ref_q, rf, nxt;
   logic [7:0]       shape;
   logic [2:0]       pidx;
   logic [CELLS-1:0] cells;

   assign cells = {word_i, {bmc_tx_pkg::PRE_CELLS{1'b0}}};
   assign shape = bmc_tx_pkg::pre_shape(pre_i);
   assign pidx  = 3'd7 - hc_i[2:0];
   assign rf    = (hc_i == '0) ? lvl_q : ref_q;

   always_comb begin
      if (hc_i < HC_W'(bmc_tx_pkg::PRE_HALVES)) begin
         nxt = shape[pidx] ^ rf;
      end else if (!hc_i[0]) begin
         nxt = ~lvl_q;
      end else begin
         nxt = lvl_q ^ cells[hc_i[HC_W-1:1]];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         ref_q <= 1'b0;
      end else begin
         lvl_q <= nxt;
         if (hc_i == '0) begin
            ref_q <= lvl_q;
         end
      end
   end

   assign lvl_o = lvl_q;

endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx #(
   parameter int unsigned SAMPLE_W     = 16,
   parameter int unsigned AUX_W        = 4,
   parameter int unsigned EXT_W        = 4,
   parameter int unsigned BLOCK_FRAMES = 192,
   parameter int unsigned ACC_W        = 2,
   parameter int unsigned ACC_POS      = 28,
   localparam int unsigned DATA_CELLS  = AUX_W + EXT_W + SAMPLE_W + bmc_tx_pkg::FLAG_CELLS,
   localparam int unsigned HALVES      = 2 * (DATA_CELLS + bmc_tx_pkg::PRE_CELLS),
   localparam int unsigned HC_W        = $clog2(HALVES),
   localparam int unsigned FR_W        = $clog2(BLOCK_FRAMES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic                smp_vld_i,
   input  logic [SAMPLE_W-1:0] smp_l_i,
   input  logic [SAMPLE_W-1:0] smp_r_i,
   input  logic                interp_l_i,
   input  logic                interp_r_i,
   input  logic                user_i,
   input  logic [ACC_W-1:0]    acc_i,
   output logic                line_o,
   output logic                line_oe_o
);

   if (AUX_W + EXT_W + SAMPLE_W != 24) begin : g_chk_width
      $error("bmc_audio_tx: aux, extension and sample widths must total 24");
   end
   if (ACC_POS + ACC_W > BLOCK_FRAMES) begin : g_chk_acc
      $error("bmc_audio_tx: accuracy field does not fit in a block");
   end
   if (BLOCK_FRAMES < 2) begin : g_chk_blk
      $error("bmc_audio_tx: a block needs at least two frames");
   end

   logic [HC_W-1:0]       hc;
   logic                  right;
   logic [FR_W-1:0]       frame;
   logic                  sf_start, frame_start;
   logic [DATA_CELLS-1:0] word;
   logic                  lvl;
   logic                  oe_q;
   bmc_tx_pkg::pre_kind_e pre;

   bmc_tx_timer #(
      .HALVES       (HALVES),
      .BLOCK_FRAMES (BLOCK_FRAMES)
   ) i_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .hc_o          (hc),
      .right_o       (right),
      .frame_o       (frame),
      .sf_start_o    (sf_start),
      .frame_start_o (frame_start)
   );

   bmc_tx_word #(
      .SAMPLE_W     (SAMPLE_W),
      .AUX_W        (AUX_W),
      .EXT_W        (EXT_W),
      .BLOCK_FRAMES (BLOCK_FRAMES),
      .ACC_W        (ACC_W),
      .ACC_POS      (ACC_POS)
   ) i_word (
      .clk           (clk),
      .rst_n         (rst_n),
      .smp_vld_i     (smp_vld_i),
      .smp_l_i       (smp_l_i),
      .smp_r_i       (smp_r_i),
      .interp_l_i    (interp_l_i),
      .interp_r_i    (interp_r_i),
      .user_i        (user_i),
      .acc_i         (acc_i),
      .sf_start_i    (sf_start),
      .frame_start_i (frame_start),
      .right_i       (right),
      .frame_i       (frame),
      .word_o        (word)
   );

   always_comb begin
      if (right)              pre = bmc_tx_pkg::PRE_RGT;
      else if (frame == '0)   pre = bmc_tx_pkg::PRE_BLK;
      else                    pre = bmc_tx_pkg::PRE_LFT;
   end

   bmc_tx_line #(
      .HALVES (HALVES)
   ) i_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .hc_i   (hc),
      .pre_i  (pre),
      .word_i (word),
      .lvl_o  (lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= en_i;
   end

   assign line_oe_o = oe_q;
   assign line_o    = oe_q & lvl;

endmodule

// File: rtl/bmc_audio_tx_chk.sv
module bmc_audio_tx_chk #(
   parameter int unsigned HALVES       = 64,
   parameter int unsigned BLOCK_FRAMES = 192,
   localparam int unsigned HC_W        = $clog2(HALVES),
   localparam int unsigned FR_W        = $clog2(BLOCK_FRAMES)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            en_i,
   input logic            line_o,
   input logic            line_oe_o,
   input logic [HC_W-1:0] hc,
   input logic            lvl,
   input logic [FR_W-1:0] frame
);

   logic start_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        start_c <= 1'b0;
      else if (hc == '0) start_c <= lvl;
   end

   a_r9_oe_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (line_oe_o == $past(en_i)));

   a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !line_oe_o |-> !line_o);

   a_r8_cell_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (hc >= HC_W'(bmc_tx_pkg::PRE_HALVES) && !hc[0]) |=> (lvl != $past(lvl)));

   a_r8_preamble_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (hc == '0) |=> (lvl != $past(lvl)));

   a_r7_even_close: assert property (@(posedge clk) disable iff (!rst_n)
      (hc == HC_W'(HALVES - 1)) |=> (lvl == start_c));

   a_r3_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
      frame < FR_W'(BLOCK_FRAMES));

endmodule

bind bmc_audio_tx bmc_audio_tx_chk #(
   .HALVES       (HALVES),
   .BLOCK_FRAMES (BLOCK_FRAMES)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en_i      (en_i),
   .line_o    (line_o),
   .line_oe_o (line_oe_o),
   .hc        (hc),
   .lvl       (lvl),
   .frame     (frame)
);

// File: tb/test_bmc_audio_tx.sv
module test_bmc_audio_tx;

   localparam int SF_OFF = 772;               // subframe sent with the enable low
   localparam int TOTAL  = 776 * 64;          // half-cells to run
   localparam int WD     = 60000;

   // {left, right, interp_l, interp_r, user_l, user_r}
   localparam logic [35:0] STIM [8] = '{
      {16'h0000, 16'hFFFF, 4'b0001},
      {16'h8000, 16'h0001, 4'b1010},
      {16'h1234, 16'hABCD, 4'b0111},
      {16'hFFFF, 16'h0000, 4'b1100},
      {16'hAAAA, 16'h5555, 4'b0010},
      {16'h7FFF, 16'h8001, 4'b1001},
      {16'h0F0F, 16'hF0F0, 4'b0100},
      {16'hC3A5, 16'h5A3C, 4'b1111}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i = 1'b1;
   logic        smp_vld_i = 1'b0;
   logic [15:0] smp_l_i = '0, smp_r_i = '0;
   logic        interp_l_i = 1'b0, interp_r_i = 1'b0;
   logic        user_i = 1'b0;
   logic [1:0]  acc_i = 2'b00;
   logic        line_o, line_oe_o;

   int   tests = 0;
   int   fails = 0;
   bit   done  = 1'b0;
   logic [63:0] hb, ob;
   logic prev_lvl = 1'b0;
   bit   skip_pol = 1'b0;

   always #2.5 clk = ~clk;

   bmc_audio_tx i_bmc_audio_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .smp_vld_i  (smp_vld_i),
      .smp_l_i    (smp_l_i),
      .smp_r_i    (smp_r_i),
      .interp_l_i (interp_l_i),
      .interp_r_i (interp_r_i),
      .user_i     (user_i),
      .acc_i      (acc_i),
      .line_o     (line_o),
      .line_oe_o  (line_oe_o)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] acc_of(input int f);
      return (f / 192 == 0) ? 2'b01 : 2'b10;
   endfunction

   task automatic drive(input int n);
      int f = n / 128;
      bit r = ((n / 64) % 2) == 1;
      logic [35:0] e = STIM[f % 8];
      user_i     = r ? e[0] : e[1];
      smp_vld_i  = (n % 128 == 40);
      smp_l_i    = e[35:20];
      smp_r_i    = e[19:4];
      interp_l_i = e[3];
      interp_r_i = e[2];
      acc_i      = acc_of(f);
      en_i       = (n / 64 != SF_OFF);
   endtask

   task automatic check_sub(input int sf);
      int f = sf / 2;
      int fb = f % 192;
      bit r = (sf % 2) == 1;
      logic [7:0]  pre, got8;
      logic [31:0] d;
      logic [15:0] exp_s;
      logic        exp_v, exp_u, exp_c;
      logic [1:0]  acc;
      int bad = 0;
      if (sf == SF_OFF) begin
         for (int i = 0; i < 64; i++) if (hb[i] || ob[i]) bad++;
         chk(bad == 0, "R9 line released and quiet while disabled", bad, 0);
         skip_pol = 1'b1;
         return;
      end
      pre = r ? 8'b11100100 : ((fb == 0) ? 8'b11101000 : 8'b11100010);
      for (int i = 0; i < 8; i++) got8[7-i] = hb[i];
      if (skip_pol) begin
         chk(ob[0] == 1'b1, "R9 enable back after one cycle", ob[0], 1);
         chk(got8 == pre || got8 == ~pre, "R9 timing kept across disable", got8, pre);
      end else begin
         chk(hb[0] != prev_lvl, "R8 preamble polarity", hb[0], ~prev_lvl);
         if (fb == 0 && !r)
            chk(got8 == (pre ^ {8{prev_lvl}}), "R3 block-start preamble", got8, pre ^ {8{prev_lvl}});
         else
            chk(got8 == (pre ^ {8{prev_lvl}}), "R2 preamble", got8, pre ^ {8{prev_lvl}});
      end
      d = '0;
      for (int s = 4; s < 32; s++) begin
         if (hb[2*s] == hb[2*s-1]) bad++;
         d[s] = hb[2*s] ^ hb[2*s+1];
      end
      chk(bad == 0, "R8 cell boundary toggles", bad, 0);
      chk(d[11:4] == 8'h00, "R1 aux and extension zero", d[11:4], 0);
      if (f == 0) begin
         exp_s = '0; exp_v = 1'b0;
      end else begin
         exp_s = r ? STIM[(f-1)%8][19:4] : STIM[(f-1)%8][35:20];
         exp_v = r ? STIM[(f-1)%8][2]    : STIM[(f-1)%8][3];
      end
      chk(d[27:12] == exp_s, "R1/R10 audio sample LSB first", d[27:12], exp_s);
      chk(d[28] == exp_v, "R4 validity", d[28], exp_v);
      exp_u = r ? STIM[f%8][0] : STIM[f%8][1];
      chk(d[29] == exp_u, "R5 user bit", d[29], exp_u);
      acc = acc_of(f);
      exp_c = (fb == 28) ? acc[0] : ((fb == 29) ? acc[1] : 1'b0);
      chk(d[30] == exp_c, "R6 channel status", d[30], exp_c);
      chk(^d[31:4] == 1'b0, "R7 even parity", d[31], ^d[30:4]);
      prev_lvl = hb[63];
      skip_pol = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(line_o == 1'b0 && line_oe_o == 1'b0, "R11 reset state", {line_oe_o, line_o}, 0);
      rst_n = 1'b1;
      for (int n = 0; n < TOTAL; n++) begin
         drive(n);
         @(posedge clk);
         @(negedge clk);
         hb[n % 64] = line_o;
         ob[n % 64] = line_oe_o;
         if (n == 0) chk(line_o == 1'b1 && line_oe_o == 1'b1, "R11 first half-cell", line_o, 1);
         if (n % 64 == 63) check_sub(n / 64);
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", WD, TOTAL);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule